// File: doc/BRIEF.md
# UART receiver with tagged receive FIFO

This block turns an asynchronous serial line into a queue of received characters. It samples the line once per pulse of an external oversampling tick, at thirteen ticks per bit. It detects a start bit on a falling edge and confirms it at mid-bit. It then collects seven or eight data bits, least significant first, and checks an optional even or odd parity bit and the stop bit.

Every finished character enters a sixteen-entry queue as a ten-bit word. The word holds the data byte and two error flags, so a host that pops it gets the character and its parity and framing status together. The block reports the queue fill level and almost-full and full levels. It pulses a line when a character is lost to a full queue, and another when data has waited in the queue for a programmable number of ticks with no new arrival. A loopback input swaps the receive source to the local transmit line.

Top module: `uart_rx_tagged`

## Requirements
- R1: A frame is one low start bit, then data bits least significant first, then optional parity, then stop bit(s). The popped word holds the data in bits 7:0, a parity-error flag in bit 8 and a framing-error flag in bit 9.
- R2: With `len8` low, seven data bits are received and bit 7 of the stored data is 0. With `len8` high, eight data bits are received.
- R3: With `par_en` high, one parity bit follows the data. `par_odd` high selects odd parity and low selects even. A mismatch sets bit 8 of the word. With `par_en` low, no parity bit is expected and bit 8 is 0.
- R4: A low first stop bit sets bit 9 of the word. With `two_stop` high, the receiver waits through a second stop bit but does not check it.
- R5: A low level must still be present at sample 6 of 13 after the falling edge. A shorter low pulse is ignored and stores nothing.
- R6: The queue holds up to 16 words in arrival order. `rx_entry` always shows the oldest word. `rx_count` runs from 0 to 16, and a `pop` while the queue is empty has no effect.
- R7: `afull` is high while `rx_count` is 12 or more. `full` is high while `rx_count` is 16.
- R8: A character that completes while the queue is full, with no pop in the same cycle, is discarded. `ovr_pulse` goes high for one clock, and the queued words and the count are unchanged.
- R9: While the queue is not empty, `tmo_pulse` goes high for one clock once `idle_limit` ticks pass with no new character. It does not fire again until another character arrives.
- R10: While `rx_en` is low, the receiver stays idle and no characters are stored.
- R11: With `loop_en` high, the receiver samples `txd_loop` instead of `rxd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Oversampling tick, one clock wide, 13 per bit |
| rx_en | input | 1 | Receiver enable |
| loop_en | input | 1 | Select `txd_loop` as the receive source |
| rxd | input | 1 | Serial receive line |
| txd_loop | input | 1 | Local transmit line for loopback |
| len8 | input | 1 | 1: eight data bits, 0: seven |
| par_en | input | 1 | Parity bit present and checked |
| par_odd | input | 1 | 1: odd parity, 0: even |
| two_stop | input | 1 | Two stop bits per frame |
| idle_limit | input | 12 | Idle period for the timeout, in ticks |
| pop | input | 1 | Remove the oldest word |
| rx_entry | output | 10 | Oldest word: {ferr, perr, data[7:0]} |
| rx_count | output | 5 | Number of words queued |
| afull | output | 1 | Queue holds 12 or more words |
| full | output | 1 | Queue holds 16 words |
| ovr_pulse | output | 1 | Character lost to a full queue |
| tmo_pulse | output | 1 | Receive idle timeout |

## Verification
The bench uses the default parameters: 13 samples per bit with the start check at sample 6, a 16-entry queue with the almost-full mark at 12, and a 12-bit idle timer. It drives one tick every four clocks, so a bit lasts 52 clocks. With this depth, seventeen frames fill the queue, cross the almost-full mark and overrun it. The 12-bit timer lets a limit of 100 ticks be checked on both sides of its expiry.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef struct packed {
    logic       ferr;
    logic       perr;
    logic [7:0] data;
  } rx_entry_t;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP1,
    RX_STOP2
  } rx_state_e;

endpackage

// File: rtl/uart_rx_deframer.sv
module uart_rx_deframer
  import uart_rx_pkg::*;
#(
  parameter int OSR = 13,
  parameter int MID = 6
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      rx_en,
  input  logic      line,
  input  logic      len8,
  input  logic      par_en,
  input  logic      par_odd,
  input  logic      two_stop,
  output logic      push,
  output rx_entry_t push_word
);

  localparam int SW = $clog2(OSR);

  rx_state_e      st_q, st_d;
  logic [SW-1:0]  smp_q, smp_d;
  logic [2:0]     bit_q, bit_d;
  logic [7:0]     sh_q, sh_d;
  logic           pacc_q, pacc_d;
  logic           perr_q, perr_d;
  logic           ferr_q, ferr_d;
  logic           prev_q, prev_d;

  logic           smp_mid, smp_last;
  logic [2:0]     last_bit;

  assign smp_mid  = (smp_q == SW'(MID));
  assign smp_last = (smp_q == SW'(OSR - 1));
  assign last_bit = len8 ? 3'd7 : 3'd6;

  always_comb begin
    st_d   = st_q;
    smp_d  = smp_q;
    bit_d  = bit_q;
    sh_d   = sh_q;
    pacc_d = pacc_q;
    perr_d = perr_q;
    ferr_d = ferr_q;
    prev_d = prev_q;
    push   = 1'b0;
    push_word.ferr = ferr_q;
    push_word.perr = perr_q;
    push_word.data = len8 ? sh_q : {1'b0, sh_q[7:1]};
    if (!rx_en) begin
      st_d  = RX_IDLE;
      smp_d = '0;
      if (tick) prev_d = line;
    end else if (tick) begin
      prev_d = line;
      smp_d  = smp_last ? '0 : smp_q + 1'b1;
      unique case (st_q)
        RX_IDLE: begin
          smp_d = SW'(1);
          if (prev_q && !line) st_d = RX_START;
        end
        RX_START: begin
          if (smp_mid && line) begin
            st_d = RX_IDLE;
          end else if (smp_last) begin
            st_d   = RX_DATA;
            bit_d  = '0;
            pacc_d = 1'b0;
            perr_d = 1'b0;
          end
        end
        RX_DATA: begin
          if (smp_mid) begin
            sh_d   = {line, sh_q[7:1]};
            pacc_d = pacc_q ^ line;
          end
          if (smp_last) begin
            if (bit_q == last_bit) st_d = par_en ? RX_PAR : RX_STOP1;
            else                   bit_d = bit_q + 1'b1;
          end
        end
        RX_PAR: begin
          if (smp_mid)  perr_d = pacc_q ^ line ^ par_odd;
          if (smp_last) st_d = RX_STOP1;
        end
        RX_STOP1: begin
          if (smp_mid) begin
            ferr_d = !line;
            if (!two_stop) begin
              push           = 1'b1;
              push_word.ferr = !line;
              st_d           = RX_IDLE;
            end
          end else if (smp_last) begin
            st_d = RX_STOP2;
          end
        end
        RX_STOP2: begin
          if (smp_mid) begin
            push = 1'b1;
            st_d = RX_IDLE;
          end
        end
        default: st_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_IDLE;
      smp_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      pacc_q <= 1'b0;
      perr_q <= 1'b0;
      ferr_q <= 1'b0;
      prev_q <= 1'b1;
    end else begin
      st_q   <= st_d;
      smp_q  <= smp_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      pacc_q <= pacc_d;
      perr_q <= perr_d;
      ferr_q <= ferr_d;
      prev_q <= prev_d;
    end
  end

  a_r10_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> st_q == RX_IDLE);
  a_r4_push_from_stop: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (st_q == RX_STOP1 || st_q == RX_STOP2));
  a_r2_short_char_bit7: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !len8) |-> !push_word.data[7]);
  a_r3_no_parity_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !par_en) |-> !push_word.perr);

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AFULL = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  rx_entry_t                  push_word,
  input  logic                       pop,
  output rx_entry_t                  rd_word,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       afull,
  output logic                       full,
  output logic                       ovr
);

  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  rx_entry_t      mem_q [DEPTH];
  logic [AW-1:0]  wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic           ovr_q, ovr_d;
  logic           do_push, do_pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign do_pop  = pop && (cnt_q != '0);
  assign do_push = push && ((cnt_q != CW'(DEPTH)) || do_pop);

  always_comb begin
    wr_d  = do_push ? bump(wr_q) : wr_q;
    rd_d  = do_pop  ? bump(rd_q) : rd_q;
    cnt_d = cnt_q + CW'(do_push) - CW'(do_pop);
    ovr_d = push && !do_push;
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wr_q] <= push_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
      ovr_q <= ovr_d;
    end
  end

  assign rd_word = mem_q[rd_q];
  assign count   = cnt_q;
  assign afull   = (cnt_q >= CW'(AFULL));
  assign full    = (cnt_q == CW'(DEPTH));
  assign ovr     = ovr_q;

  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  a_r6_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && cnt_q != CW'(DEPTH)) |=> cnt_q == $past(cnt_q) + 1'b1);
  a_r8_ovr_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q |-> $past(cnt_q) == CW'(DEPTH));
  a_r8_ovr_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q |-> cnt_q == $past(cnt_q));

endmodule

// File: rtl/uart_rx_idle_timer.sv
module uart_rx_idle_timer #(
  parameter int TW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          push,
  input  logic          nonempty,
  input  logic [TW-1:0] limit,
  output logic          tmo
);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          tmo_q, tmo_d;

  always_comb begin
    cnt_d = cnt_q;
    tmo_d = 1'b0;
    if (push || !nonempty) begin
      cnt_d = '0;
    end else if (tick && cnt_q != limit) begin
      cnt_d = cnt_q + 1'b1;
      tmo_d = (cnt_d == limit);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tmo_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      tmo_q <= tmo_d;
    end
  end

  assign tmo = tmo_q;

  a_r9_tmo_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_q |-> $past(nonempty));
  a_r9_tmo_single: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_q |=> !tmo_q);

endmodule

// File: rtl/uart_rx_tagged.sv
module uart_rx_tagged
  import uart_rx_pkg::*;
#(
  parameter int OSR   = 13,
  parameter int MID   = 6,
  parameter int DEPTH = 16,
  parameter int AFULL = 12,
  parameter int TW    = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tick,
  input  logic                       rx_en,
  input  logic                       loop_en,
  input  logic                       rxd,
  input  logic                       txd_loop,
  input  logic                       len8,
  input  logic                       par_en,
  input  logic                       par_odd,
  input  logic                       two_stop,
  input  logic [TW-1:0]              idle_limit,
  input  logic                       pop,
  output logic [9:0]                 rx_entry,
  output logic [$clog2(DEPTH+1)-1:0] rx_count,
  output logic                       afull,
  output logic                       full,
  output logic                       ovr_pulse,
  output logic                       tmo_pulse
);

  logic      sync1_q, sync2_q;
  logic      push;
  rx_entry_t push_word, rd_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b1;
      sync2_q <= 1'b1;
    end else begin
      sync1_q <= loop_en ? txd_loop : rxd;
      sync2_q <= sync1_q;
    end
  end

  uart_rx_deframer #(.OSR(OSR), .MID(MID)) u_deframer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rx_en(rx_en), .line(sync2_q),
    .len8(len8), .par_en(par_en), .par_odd(par_odd), .two_stop(two_stop),
    .push(push), .push_word(push_word)
  );

  uart_rx_fifo #(.DEPTH(DEPTH), .AFULL(AFULL)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .push_word(push_word), .pop(pop),
    .rd_word(rd_word), .count(rx_count), .afull(afull), .full(full), .ovr(ovr_pulse)
  );

  uart_rx_idle_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .push(push),
    .nonempty(rx_count != '0), .limit(idle_limit), .tmo(tmo_pulse)
  );

  assign rx_entry = rd_word;

endmodule

// File: tb/uart_rx_tagged_tb.sv
module uart_rx_tagged_tb;

  localparam int BIT_CLK = 52;

  logic        clk, rst_n, rx_en, loop_en, drv;
  logic        len8, par_en, par_odd, two_stop, pop;
  logic [11:0] idle_limit;
  logic [9:0]  rx_entry;
  logic [4:0]  rx_count;
  logic        afull, full, ovr_pulse, tmo_pulse;
  logic [1:0]  tcnt;
  logic        tick, rxd, txd_loop;
  int          n_run, n_fail, ovr_seen, tmo_seen;

  // {len8,par_en,par_odd,two_stop, data, bad_par, stop1, stop2, expected word}
  localparam logic [24:0] VEC [0:8] = '{
    {1'b1,1'b0,1'b0,1'b0, 8'hA5, 1'b0,1'b1,1'b1, 10'h0A5},
    {1'b0,1'b0,1'b0,1'b0, 8'hD3, 1'b0,1'b1,1'b1, 10'h053},
    {1'b1,1'b1,1'b0,1'b0, 8'h3C, 1'b0,1'b1,1'b1, 10'h03C},
    {1'b1,1'b1,1'b1,1'b0, 8'h3C, 1'b1,1'b1,1'b1, 10'h13C},
    {1'b1,1'b1,1'b1,1'b0, 8'h81, 1'b0,1'b1,1'b1, 10'h081},
    {1'b1,1'b0,1'b0,1'b0, 8'h5A, 1'b0,1'b0,1'b1, 10'h25A},
    {1'b1,1'b0,1'b0,1'b1, 8'hF0, 1'b0,1'b1,1'b0, 10'h0F0},
    {1'b0,1'b1,1'b0,1'b0, 8'h7F, 1'b1,1'b0,1'b1, 10'h37F},
    {1'b0,1'b1,1'b1,1'b1, 8'h01, 1'b0,1'b1,1'b1, 10'h001}
  };

  uart_rx_tagged u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rx_en(rx_en), .loop_en(loop_en),
    .rxd(rxd), .txd_loop(txd_loop), .len8(len8), .par_en(par_en),
    .par_odd(par_odd), .two_stop(two_stop), .idle_limit(idle_limit), .pop(pop),
    .rx_entry(rx_entry), .rx_count(rx_count), .afull(afull), .full(full),
    .ovr_pulse(ovr_pulse), .tmo_pulse(tmo_pulse)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) tcnt <= '0;
    else        tcnt <= tcnt + 1'b1;
  end
  assign tick     = (tcnt == 2'd3);
  assign rxd      = loop_en ? 1'b1 : drv;
  assign txd_loop = loop_en ? drv : 1'b1;

  always @(negedge clk) begin
    if (rst_n && ovr_pulse) ovr_seen++;
    if (rst_n && tmo_pulse) tmo_seen++;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    drv = b;
    repeat (BIT_CLK) @(negedge clk);
  endtask

  task automatic send_frame(input logic l8, pe, po, ts, input logic [7:0] d,
                            input logic bp, s1, s2);
    len8 = l8; par_en = pe; par_odd = po; two_stop = ts;
    send_bit(1'b0);
    for (int i = 0; i < (l8 ? 8 : 7); i++) send_bit(d[i]);
    if (pe) send_bit((l8 ? ^d : ^d[6:0]) ^ po ^ bp);
    send_bit(s1);
    if (ts) send_bit(s2);
    send_bit(1'b1);
  endtask

  task automatic pop_check(input string tag, input logic [9:0] exp);
    check(tag, 32'(rx_entry), 32'(exp));
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    n_run = 0; n_fail = 0; ovr_seen = 0; tmo_seen = 0;
    rst_n = 1'b0; rx_en = 1'b1; loop_en = 1'b0; drv = 1'b1; pop = 1'b0;
    len8 = 1'b1; par_en = 1'b0; par_odd = 1'b0; two_stop = 1'b0;
    idle_limit = 12'd4000;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (BIT_CLK) @(negedge clk);

    // reset state (R6, R7)
    check("R6 reset count", 32'(rx_count), 0);
    check("R7 reset afull", 32'(afull), 0);
    check("R7 reset full", 32'(full), 0);
    check("R8 reset ovr", 32'(ovr_pulse), 0);

    // vector table: formats, parity, framing (R1 R2 R3 R4)
    for (int v = 0; v < 9; v++) begin
      send_frame(VEC[v][24], VEC[v][23], VEC[v][22], VEC[v][21], VEC[v][20:13],
                 VEC[v][12], VEC[v][11], VEC[v][10]);
    end
    check("R6 count after table", 32'(rx_count), 9);
    for (int v = 0; v < 9; v++) begin
      pop_check($sformatf("R1 R2 R3 R4 vector %0d", v), VEC[v][9:0]);
    end
    check("R6 drained", 32'(rx_count), 0);

    // pop on empty is ignored (R6)
    pop = 1'b1; @(negedge clk); pop = 1'b0; @(negedge clk);
    check("R6 pop on empty", 32'(rx_count), 0);

    // short low glitch does not start a frame (R5)
    drv = 1'b0; repeat (12) @(negedge clk);
    drv = 1'b1; repeat (2*BIT_CLK) @(negedge clk);
    check("R5 glitch ignored", 32'(rx_count), 0);
    send_frame(1'b1, 1'b0, 1'b0, 1'b0, 8'h6E, 1'b0, 1'b1, 1'b1);
    check("R5 frame after glitch count", 32'(rx_count), 1);
    pop_check("R5 frame after glitch data", 10'h06E);

    // receiver disabled (R10)
    rx_en = 1'b0;
    send_frame(1'b1, 1'b0, 1'b0, 1'b0, 8'h42, 1'b0, 1'b1, 1'b1);
    check("R10 disabled stores nothing", 32'(rx_count), 0);
    rx_en = 1'b1;
    repeat (BIT_CLK) @(negedge clk);

    // loopback source (R11)
    loop_en = 1'b1;
    send_frame(1'b1, 1'b0, 1'b0, 1'b0, 8'hC7, 1'b0, 1'b1, 1'b1);
    check("R11 loopback count", 32'(rx_count), 1);
    pop_check("R11 loopback data", 10'h0C7);
    loop_en = 1'b0;
    repeat (BIT_CLK) @(negedge clk);

    // fill, thresholds, overrun (R7 R8)
    for (int i = 0; i < 16; i++) begin
      send_frame(1'b1, 1'b0, 1'b0, 1'b0, 8'(8'h20 + i), 1'b0, 1'b1, 1'b1);
      check($sformatf("R6 fill count %0d", i + 1), 32'(rx_count), 32'(i + 1));
      check($sformatf("R7 afull at %0d", i + 1), 32'(afull), 32'(i + 1 >= 12));
      check($sformatf("R7 full at %0d", i + 1), 32'(full), 32'(i + 1 == 16));
    end
    check("R8 no overrun before full", 32'(ovr_seen), 0);
    send_frame(1'b1, 1'b0, 1'b0, 1'b0, 8'h99, 1'b0, 1'b1, 1'b1);
    check("R8 overrun pulse", 32'(ovr_seen), 1);
    check("R8 count held", 32'(rx_count), 16);
    for (int i = 0; i < 16; i++) begin
      pop_check($sformatf("R8 R6 order %0d", i), 10'(8'h20 + i));
    end
    check("R8 lost char not stored", 32'(rx_count), 0);

    // idle timeout (R9)
    idle_limit = 12'd100;
    tmo_seen = 0;
    send_frame(1'b1, 1'b0, 1'b0, 1'b0, 8'h3A, 1'b0, 1'b1, 1'b1);
    repeat (240) @(negedge clk);
    check("R9 no timeout before limit", 32'(tmo_seen), 0);
    repeat (200) @(negedge clk);
    check("R9 timeout after limit", 32'(tmo_seen), 1);
    repeat (800) @(negedge clk);
    check("R9 timeout fires once", 32'(tmo_seen), 1);
    pop_check("R9 data kept", 10'h03A);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule